// File: doc/BRIEF.md
# Floating-Point Register Store Sequencer

This block turns one floating-point store command into a stream of 32-bit memory word writes. A command carries the mode bits of a coprocessor store instruction word (pre-index, up/down, low register bit, write-back), the value of the base address register, the first register number, an 8-bit word offset and a precision select. The block reads the source registers one word at a time through a read port into a 32-entry, 32-bit register file. That file can also be seen as sixteen 64-bit pairs. Each word goes out on a valid/ready write channel, one per cycle while the receiver is ready.

Three store shapes are decoded. The first is a store of one register. The second stores a run of consecutive single- or double-precision registers. The third is the unknown-precision form, which has an odd offset: its double-precision words are followed by one padding word. Double-precision registers leave as two words, and their order depends on a big-endian mode input. For the multi-register forms the block can also give an updated base address. It raises a flag instead of writing when the register list cannot be stored.

Top module: `fpreg_store_seq`

## Requirements
- R1: A command with cmdP=1 and cmdW=0 and cmdDouble=0 writes exactly one word at cmdBase+4*cmdOffset (cmdU=1) or cmdBase-4*cmdOffset (cmdU=0). The word comes from single register s={cmdFirst,cmdD}, where cmdD is the LSB.
- R2: A command with cmdP=1 and cmdW=0 and cmdDouble=1 writes the two words of double register cmdFirst to the addresses A and A+4. A is formed as in R1. No base write-back follows this command.
- R3: Double register n is made of single registers 2n+1 (bits 63:32) and 2n (bits 31:0). With bigEndian=1 the high half goes to the lower address. With bigEndian=0 the low half goes to the lower address.
- R4: With cmdP=0 and cmdU=1 (increment), a multi-register store starts at cmdBase and adds 4 per word. Registers are stored in strictly increasing number. For singles (cmdDouble=0) the list is cmdOffset registers from {cmdFirst,cmdD}.
- R5: With cmdP=1 and cmdU=0 and cmdW=1 (decrement), the first word goes to cmdBase-4*cmdOffset and later words rise by 4.
- R6: A double-precision multi-register store with an even cmdOffset stores cmdOffset/2 registers from cmdFirst upward, which is cmdOffset words.
- R7: A double-precision multi-register store with an odd cmdOffset stores (cmdOffset-1)/2 registers as in R6. It then writes one further word whose value is 0, for cmdOffset words in all.
- R8: A multi-register store with cmdW=1 pulses wbValid for exactly one cycle, the cycle after its last word is accepted. wbAddr then shows cmdBase+4*cmdOffset when incrementing or cmdBase-4*cmdOffset when decrementing. With cmdW=0 wbValid stays low.
- R9: A multi-register command is invalid in any of these cases: cmdOffset=0; cmdFirst+cmdOffset/2>16 for doubles; {cmdFirst,cmdD}+cmdOffset>32 for singles; cmdP=cmdU=0; or cmdP=cmdU=cmdW=1. An invalid command writes no word and gives no write-back. badList is high for one cycle, the cycle after acceptance.
- R10: While wrValid is high and wrReady is low, wrValid, wrAddr and wrData hold.
- R11: After reset cmdReady is high and wrValid, wbValid and badList are low. A command is accepted on an edge where cmdValid and cmdReady are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command can be taken |
| cmdP | input | 1 | Pre-index mode bit |
| cmdU | input | 1 | Up (add) / down (subtract) bit |
| cmdD | input | 1 | LSB of single register number |
| cmdW | input | 1 | Base write-back request |
| cmdDouble | input | 1 | 1 = double-precision registers |
| cmdBase | input | 32 | Base address register value |
| cmdFirst | input | 4 | Upper bits of first register number (double: register number) |
| cmdOffset | input | 8 | Word offset / list length field |
| bigEndian | input | 1 | Word order of double halves |
| rfIdx | output | 5 | Register file read index |
| rfData | input | 32 | Register file read data, same cycle |
| wrValid | output | 1 | Write word valid |
| wrReady | input | 1 | Write word accepted |
| wrAddr | output | 32 | Write word address |
| wrData | output | 32 | Write word data |
| wbValid | output | 1 | Base write-back strobe |
| wbAddr | output | 32 | New base value |
| badList | output | 1 | Invalid register list pulse |

## Verification
The first write word is due on wrValid in the cycle after the edge that accepts the command. Each later word appears one cycle after the handshake of the word before it. wbValid and badList are each due exactly one cycle after their cause: the last handshake for wbValid, acceptance for badList. The bench drives wrReady on the falling edge and samples all outputs just after it. It records each handshake in that same half cycle, so every word, write-back and flag is tied to the exact cycle it belongs to. Stall patterns check that a held word keeps its address.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  typedef struct packed {
    logic load;  // capture a decoded command
    logic step;  // current word accepted, advance
  } fpstStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;
endpackage

// File: rtl/fpst_datapath.sv
module fpst_datapath
  import fpst_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int REG_NUM = 32,
  parameter int OFF_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fpstStrobe_t                   strobe,
  input  logic                          cmdP,
  input  logic                          cmdU,
  input  logic                          cmdD,
  input  logic                          cmdW,
  input  logic                          cmdDouble,
  input  logic [ADDR_W-1:0]             cmdBase,
  input  logic [$clog2(REG_NUM/2)-1:0]  cmdFirst,
  input  logic [OFF_W-1:0]              cmdOffset,
  input  logic                          bigEndian,
  input  logic [DATA_W-1:0]             rfData,
  output logic [$clog2(REG_NUM)-1:0]    rfIdx,
  output logic [ADDR_W-1:0]             wrAddr,
  output logic [DATA_W-1:0]             wrData,
  output logic                          listOk,
  output logic                          lastWord,
  output logic                          wbEn,
  output logic [ADDR_W-1:0]             wbAddr
);
  localparam int REG_IDX_W = $clog2(REG_NUM);
  localparam int DREG_NUM  = REG_NUM / 2;
  localparam int DIDX_W    = $clog2(DREG_NUM);
  localparam int SUM_W     = OFF_W + 1;

  // ---- command decode (combinational, used at load) ----
  logic                 singleForm, incMode, decMode, rangeOk;
  logic [REG_IDX_W-1:0] sFirst;
  logic [ADDR_W-1:0]    offX4, startAddr, wbTarget;
  logic [OFF_W-1:0]     wordsNew;
  logic [SUM_W-1:0]     dEnd, sEnd;

  always_comb begin
    singleForm = cmdP & ~cmdW;
    incMode    = ~cmdP & cmdU;
    decMode    = cmdP & ~cmdU;
    sFirst     = {cmdFirst, cmdD};
    offX4      = ADDR_W'({cmdOffset, 2'b00});
    dEnd       = SUM_W'(cmdFirst) + SUM_W'(cmdOffset >> 1);
    sEnd       = SUM_W'(sFirst) + SUM_W'(cmdOffset);
    rangeOk    = cmdDouble ? (dEnd <= SUM_W'(DREG_NUM)) : (sEnd <= SUM_W'(REG_NUM));
    listOk     = singleForm | ((incMode | decMode) & (cmdOffset != '0) & rangeOk);
    wordsNew   = singleForm ? (cmdDouble ? OFF_W'(2) : OFF_W'(1)) : cmdOffset;
    if (singleForm)
      startAddr = cmdU ? (cmdBase + offX4) : (cmdBase - offX4);
    else if (incMode)
      startAddr = cmdBase;
    else
      startAddr = cmdBase - offX4;
    wbTarget = incMode ? (cmdBase + offX4) : (cmdBase - offX4);
  end

  // ---- sequence state ----
  logic [ADDR_W-1:0]    curAddr, wbAddrQ;
  logic [OFF_W-1:0]     wordsLeft, wordIdx;
  logic [REG_IDX_W-1:0] sBaseQ;
  logic [DIDX_W-1:0]    dBaseQ;
  logic                 dblQ, unkQ, beQ, wbEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      wbAddrQ   <= '0;
      wordsLeft <= '0;
      wordIdx   <= '0;
      sBaseQ    <= '0;
      dBaseQ    <= '0;
      dblQ      <= 1'b0;
      unkQ      <= 1'b0;
      beQ       <= 1'b0;
      wbEnQ     <= 1'b0;
    end else if (strobe.load) begin
      curAddr   <= startAddr;
      wbAddrQ   <= wbTarget;
      wordsLeft <= wordsNew;
      wordIdx   <= '0;
      sBaseQ    <= sFirst;
      dBaseQ    <= cmdFirst;
      dblQ      <= cmdDouble;
      unkQ      <= cmdDouble & ~singleForm & cmdOffset[0];
      beQ       <= bigEndian;
      wbEnQ     <= ~singleForm & cmdW;
    end else if (strobe.step) begin
      curAddr   <= curAddr + ADDR_W'(4);
      wordsLeft <= wordsLeft - OFF_W'(1);
      wordIdx   <= wordIdx + OFF_W'(1);
    end
  end

  // ---- register read index and word data ----
  logic [DIDX_W-1:0]    pairSum;
  logic [REG_IDX_W-1:0] singleSum;

  always_comb begin
    pairSum   = dBaseQ + DIDX_W'(wordIdx >> 1);
    singleSum = sBaseQ + REG_IDX_W'(wordIdx);
    rfIdx     = dblQ ? {pairSum, wordIdx[0] ^ beQ} : singleSum;
    lastWord  = (wordsLeft == OFF_W'(1));
    wrData    = (unkQ && lastWord) ? '0 : rfData;
  end

  assign wrAddr = curAddr;
  assign wbAddr = wbAddrQ;
  assign wbEn   = wbEnQ;

  // consecutive words rise by one word address
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !lastWord) |=> (curAddr == $past(curAddr) + ADDR_W'(4)));

  // a word that is not taken keeps its address
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.step && !strobe.load) |=> $stable(curAddr));
endmodule

// File: rtl/fpst_ctrl.sv
module fpst_ctrl
  import fpst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        listOk,
  input  logic        lastWord,
  input  logic        wbEn,
  input  logic        wrReady,
  output fpstStrobe_t strobe,
  output logic        cmdReady,
  output logic        wrValid,
  output logic        wbValid,
  output logic        badList
);
  seqState_t state;
  logic      accept;

  always_comb begin
    cmdReady    = (state == SEQ_IDLE);
    wrValid     = (state == SEQ_RUN);
    accept      = cmdValid & cmdReady;
    strobe.load = accept & listOk;
    strobe.step = wrValid & wrReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      wbValid <= 1'b0;
      badList <= 1'b0;
    end else begin
      badList <= accept & ~listOk;
      wbValid <= strobe.step & lastWord & wbEn;
      if (strobe.load)
        state <= SEQ_RUN;
      else if (strobe.step && lastWord)
        state <= SEQ_IDLE;
    end
  end

  assert_bad_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    badList |-> !wrValid);

  assert_wb_after_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !wrValid);

  assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid);

  assert_idle_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !listOk) |=> cmdReady);
endmodule

// File: rtl/fpreg_store_seq.sv
module fpreg_store_seq
  import fpst_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int REG_NUM = 32,
  parameter int OFF_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdValid,
  output logic                          cmdReady,
  input  logic                          cmdP,
  input  logic                          cmdU,
  input  logic                          cmdD,
  input  logic                          cmdW,
  input  logic                          cmdDouble,
  input  logic [ADDR_W-1:0]             cmdBase,
  input  logic [$clog2(REG_NUM/2)-1:0]  cmdFirst,
  input  logic [OFF_W-1:0]              cmdOffset,
  input  logic                          bigEndian,
  output logic [$clog2(REG_NUM)-1:0]    rfIdx,
  input  logic [DATA_W-1:0]             rfData,
  output logic                          wrValid,
  input  logic                          wrReady,
  output logic [ADDR_W-1:0]             wrAddr,
  output logic [DATA_W-1:0]             wrData,
  output logic                          wbValid,
  output logic [ADDR_W-1:0]             wbAddr,
  output logic                          badList
);
  fpstStrobe_t strobe;
  logic        listOk, lastWord, wbEn;

  fpst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .listOk(listOk),
    .lastWord(lastWord), .wbEn(wbEn), .wrReady(wrReady), .strobe(strobe),
    .cmdReady(cmdReady), .wrValid(wrValid), .wbValid(wbValid), .badList(badList)
  );

  fpst_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_NUM(REG_NUM), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdP(cmdP), .cmdU(cmdU), .cmdD(cmdD), .cmdW(cmdW), .cmdDouble(cmdDouble),
    .cmdBase(cmdBase), .cmdFirst(cmdFirst), .cmdOffset(cmdOffset),
    .bigEndian(bigEndian), .rfData(rfData), .rfIdx(rfIdx),
    .wrAddr(wrAddr), .wrData(wrData), .listOk(listOk), .lastWord(lastWord),
    .wbEn(wbEn), .wbAddr(wbAddr)
  );
endmodule

// File: tb/fpreg_store_seq_bench.sv
module fpreg_store_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdP = 1'b0, cmdU = 1'b0, cmdD = 1'b0, cmdW = 1'b0;
  logic        cmdDouble = 1'b0, bigEndian = 1'b0, wrReady = 1'b0;
  logic [31:0] cmdBase = '0;
  logic [3:0]  cmdFirst = '0;
  logic [7:0]  cmdOffset = '0;
  logic        cmdReady, wrValid, wbValid, badList;
  logic [4:0]  rfIdx;
  logic [31:0] rfData, wrAddr, wrData, wbAddr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] regVal(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  assign rfData = regVal(int'(rfIdx));

  fpreg_store_seq u_fpreg_store_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdP(cmdP), .cmdU(cmdU), .cmdD(cmdD), .cmdW(cmdW), .cmdDouble(cmdDouble),
    .cmdBase(cmdBase), .cmdFirst(cmdFirst), .cmdOffset(cmdOffset),
    .bigEndian(bigEndian), .rfIdx(rfIdx), .rfData(rfData),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .wbValid(wbValid), .wbAddr(wbAddr), .badList(badList)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one command, collect its outputs and compare with the model.
  task automatic exec(input string tag, input bit p, input bit u, input bit d, input bit w,
                      input bit dbl, input logic [31:0] base, input logic [3:0] first,
                      input logic [7:0] off, input bit be, input bit stall);
    logic [31:0] expA[64], expD[64], gotA[64], gotD[64];
    logic [31:0] expWbAddr, gotWbAddr, heldAddr;
    bit   single, inc, dec, ok, expWb, prevStall;
    int   n, got, wbCnt, badCnt, holdErr, sIdx;
    single = p && !w;
    inc = !p && u;
    dec = p && !u;
    sIdx = {first, d};
    if (single) ok = 1;
    else if (!(inc || dec) || off == 0) ok = 0;
    else if (dbl) ok = (int'(first) + int'(off) / 2) <= 16;
    else ok = (sIdx + int'(off)) <= 32;
    n = !ok ? 0 : single ? (dbl ? 2 : 1) : int'(off);
    expWb = ok && !single && w;
    expWbAddr = inc ? base + 32'(off) * 4 : base - 32'(off) * 4;
    for (int k = 0; k < n; k++) begin
      logic [31:0] a0;
      if (single) a0 = u ? base + 32'(off) * 4 : base - 32'(off) * 4;
      else a0 = inc ? base : base - 32'(off) * 4;
      expA[k] = a0 + 32'(k) * 4;
      if (!dbl) expD[k] = regVal(sIdx + k);
      else if (!single && off[0] && k == n - 1) expD[k] = 32'h0;
      else expD[k] = regVal(2 * (int'(first) + k / 2) + ((k % 2) ^ int'(be)));
    end
    @(negedge clk);
    cmdP = p; cmdU = u; cmdD = d; cmdW = w; cmdDouble = dbl;
    cmdBase = base; cmdFirst = first; cmdOffset = off; bigEndian = be;
    chk({tag, " R11 ready"}, 32'(cmdReady), 32'd1);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    got = 0; wbCnt = 0; badCnt = 0; holdErr = 0; prevStall = 0; heldAddr = '0;
    gotWbAddr = '0;
    for (int cyc = 0; cyc < 3 * n + 6; cyc++) begin
      wrReady = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (prevStall && (!wrValid || wrAddr !== heldAddr)) holdErr++;
      prevStall = wrValid && !wrReady;
      heldAddr = wrAddr;
      if (wrValid && wrReady) begin
        if (got < 64) begin gotA[got] = wrAddr; gotD[got] = wrData; end
        got++;
      end
      if (wbValid) begin wbCnt++; gotWbAddr = wbAddr; end
      if (badList) badCnt++;
      @(negedge clk);
    end
    wrReady = 1'b0;
    chk({tag, " word count"}, 32'(got), 32'(n));
    for (int k = 0; k < n && k < got; k++) begin
      chk($sformatf("%s addr[%0d]", tag, k), gotA[k], expA[k]);
      chk($sformatf("%s data[%0d]", tag, k), gotD[k], expD[k]);
    end
    chk({tag, " R8 writeback count"}, 32'(wbCnt), expWb ? 32'd1 : 32'd0);
    if (expWb) chk({tag, " R8 writeback addr"}, gotWbAddr, expWbAddr);
    chk({tag, " R9 bad flag count"}, 32'(badCnt), ok ? 32'd0 : 32'd1);
    if (stall) chk({tag, " R10 hold while stalled"}, 32'(holdErr), 32'd0);
  endtask

  task automatic t_reset;
    #1;
    chk("R11 cmdReady", 32'(cmdReady), 32'd1);
    chk("R11 wrValid", 32'(wrValid), 32'd0);
    chk("R11 wbValid", 32'(wbValid), 32'd0);
    chk("R11 badList", 32'(badList), 32'd0);
  endtask

  task automatic t_single;
    exec("R1 single up", 1, 1, 1, 0, 0, 32'h0000_2000, 4'd2, 8'd3, 0, 0);
    exec("R1 single down", 1, 0, 0, 0, 0, 32'h0000_2000, 4'd15, 8'd5, 0, 0);
  endtask

  task automatic t_double_single;
    exec("R2 R3 double LE", 1, 1, 0, 0, 1, 32'h0000_3000, 4'd3, 8'd2, 0, 0);
    exec("R2 R3 double BE", 1, 0, 0, 0, 1, 32'h0000_3000, 4'd3, 8'd2, 1, 0);
  endtask

  task automatic t_multi_single;
    exec("R4 R8 inc singles", 0, 1, 1, 1, 0, 32'h0000_4000, 4'd2, 8'd3, 0, 0);
    exec("R5 R8 dec singles", 1, 0, 0, 1, 0, 32'h0000_4000, 4'd4, 8'd4, 0, 0);
    exec("R4 top boundary S29..S31", 0, 1, 1, 0, 0, 32'h0000_4100, 4'd14, 8'd3, 0, 0);
  endtask

  task automatic t_multi_double;
    exec("R6 R3 doubles LE no wb", 0, 1, 0, 0, 1, 32'h0000_5000, 4'd1, 8'd6, 0, 0);
    exec("R6 R3 doubles BE dec", 1, 0, 0, 1, 1, 32'h0000_5000, 4'd12, 8'd8, 1, 0);
  endtask

  task automatic t_unknown;
    exec("R7 unknown form", 0, 1, 0, 1, 1, 32'h0000_6000, 4'd2, 8'd7, 0, 0);
    exec("R7 unknown form BE", 1, 0, 0, 1, 1, 32'h0000_6000, 4'd0, 8'd3, 1, 0);
  endtask

  task automatic t_stall;
    exec("R10 stalled doubles", 0, 1, 0, 1, 1, 32'h0000_7000, 4'd4, 8'd6, 0, 1);
  endtask

  task automatic t_invalid;
    exec("R9 zero offset", 0, 1, 0, 1, 0, 32'h0000_8000, 4'd1, 8'd0, 0, 0);
    exec("R9 single overrun", 0, 1, 0, 1, 0, 32'h0000_8000, 4'd15, 8'd3, 0, 0);
    exec("R9 double overrun", 0, 1, 0, 1, 1, 32'h0000_8000, 4'd14, 8'd6, 0, 0);
    exec("R9 P0 U0", 0, 0, 0, 1, 0, 32'h0000_8000, 4'd1, 8'd2, 0, 0);
    exec("R9 P1 U1 W1", 1, 1, 0, 1, 0, 32'h0000_8000, 4'd1, 8'd2, 0, 0);
    exec("R6 double boundary D14..D15", 0, 1, 0, 0, 1, 32'h0000_8000, 4'd14, 8'd4, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_single();
    t_double_single();
    t_multi_single();
    t_multi_double();
    t_unknown();
    t_stall();
    t_invalid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule